// File: doc/BRIEF.md
# Register-Mapped Bidirectional GPIO Port Controller

This block is a small peripheral on a synchronous register bus. It holds a bank of 16-bit control words and a 16-line general-purpose I/O port. A host writes and reads the words through an address, a write strobe, a read strobe and a data bus. The block decodes word offsets inside a 64-byte window. External input lines update a level word. The output lines follow the level word, masked by a direction word.

Output lines are refreshed only after a host write to the direction word or the level word. At that point each line whose masked level differs from the value it last drove takes the new value. Input events change the stored level but leave the driven lines alone until the next such write. One write bit in the power word also forces two more bits on.

Top module: `gpio_regblock`

## Requirements
- R1: Only address bits [5:0] are decoded, so higher address bits are ignored. The decoded byte offsets are: 0x00 mode, 0x04 data, 0x08 status, 0x0C power, 0x10 control, 0x14 interrupt request, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, and 0x24 and 0x28, which are two aliases of the level word.
- R2: Write data bits above bit 15 are discarded. The mode, data, control, interrupt request, mask and interrupt status words store bits [15:0] of the write data and read them back unchanged.
- R3: A write to the power word stores the value ORed with 0x8040 when bit 7 of the value is 1, and stores the value unchanged when bit 7 is 0.
- R4: The status word reads 0x0002 at all times. Writes to offset 0x08 change nothing.
- R5: A write to offset 0x24 or 0x28 stores (write data AND direction word) in the level word.
- R6: A read of 0x20 returns the direction word. A read of 0x24 or 0x28 returns the level word.
- R7: An offset is undecoded when address bits [1:0] are not 00 or the word index is above 10. A read of an undecoded offset returns 0. A write to an undecoded offset changes no state and sets `badAccess` high for exactly the one cycle after the write edge.
- R8: Bit n of `gpioOut` equals bit n of (level AND direction). The lines are refreshed on the second clock edge after a write to the direction or level word, and they hold their values at every other edge.
- R9: When input line n changes value, level bit n takes the new value on the next edge. This does not change `gpioOut`.
- R10: When an input change and a write to the level word happen in the same cycle, the level word takes only the written value ANDed with the direction word.
- R11: Reset clears every word except status, drives all output lines low, and clears `badAccess` and `busRdata`.
- R12: `busRdata` loads the addressed word on the clock edge where `busRe` is sampled high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (12) | Byte address; only bits [5:0] are decoded |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | BUS_W (32) | Write data; bits [15:0] are used |
| busRdata | output | REG_W (16) | Registered read data |
| badAccess | output | 1 | One-cycle flag after a write to an undecoded offset |
| gpioIn | input | REG_W (16) | External input lines |
| gpioOut | output | REG_W (16) | Driven output lines (level AND direction) |

## Verification
On every cycle the assertions check these behaviours:
- the power-bit forcing;
- status readback;
- zero data on undecoded reads, and the hold of read data between reads;
- the source of `badAccess`;
- the masked level stored by a level write;
- the rule that output lines move only on the edge after a refresh, and then to the masked level.

The bench's scenarios show the rest:
- address aliasing through the upper address bits;
- truncation of write data;
- the absence of side effects for ignored writes;
- the way input events update the level word without touching the lines;
- which source wins when an input change and a level write collide;
- the reset state.

// File: rtl/gpio_regblock_pkg.sv
package gpio_regblock_pkg;

  // Word index order matches the byte offset divided by four.
  typedef enum logic [3:0] {
    SEL_MODE   = 4'd0,
    SEL_DATA   = 4'd1,
    SEL_STATUS = 4'd2,
    SEL_POWER  = 4'd3,
    SEL_CTRL   = 4'd4,
    SEL_IRQREQ = 4'd5,
    SEL_IMASK  = 4'd6,
    SEL_ISTAT  = 4'd7,
    SEL_DIR    = 4'd8,
    SEL_LEVEL  = 4'd9,
    SEL_NONE   = 4'd15
  } regSel_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regSel_e sel;
    logic    refresh;
  } strobe_t;

  localparam int BANK_N = 8;

  function automatic regSel_e decodeOffset(input logic [5:0] off);
    regSel_e res;
    if (off[1:0] != 2'b00) begin
      res = SEL_NONE;
    end else if (off[5:2] <= 4'd8) begin
      res = regSel_e'(off[5:2]);
    end else if (off[5:2] == 4'd9 || off[5:2] == 4'd10) begin
      res = SEL_LEVEL;
    end else begin
      res = SEL_NONE;
    end
    return res;
  endfunction

endpackage

// File: rtl/gpio_regblock_ctrl.sv
module gpio_regblock_ctrl
  import gpio_regblock_pkg::*;
#(
  parameter int DEC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEC_W-1:0] offset,
  input  logic             busWe,
  input  logic             busRe,
  output strobe_t          strobe
);

  regSel_e sel;
  logic    refreshPend;

  assign sel = decodeOffset(offset[5:0]);

  // A direction or level write schedules an output refresh for the next edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshPend <= 1'b0;
    end else begin
      refreshPend <= busWe && (sel == SEL_DIR || sel == SEL_LEVEL);
    end
  end

  always_comb begin
    strobe.wrEn    = busWe;
    strobe.rdEn    = busRe;
    strobe.sel     = sel;
    strobe.refresh = refreshPend;
  end

endmodule

// File: rtl/gpio_regblock_dp.sv
module gpio_regblock_dp
  import gpio_regblock_pkg::*;
#(
  parameter int          REG_W      = 16,
  parameter logic [15:0] STATUS_VAL = 16'h0002,
  parameter int          PWR_TRIG   = 7,
  parameter logic [15:0] PWR_FORCE  = 16'h8040
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] gpioIn,
  output logic [REG_W-1:0] rdData,
  output logic             badAccess,
  output logic [REG_W-1:0] gpioOut,
  output logic [REG_W-1:0] levelQ,
  output logic [REG_W-1:0] dirQ,
  output logic [REG_W-1:0] powerQ
);

  logic [REG_W-1:0] regBank [BANK_N];
  logic [REG_W-1:0] prevIn;
  logic [REG_W-1:0] inChg;
  logic [REG_W-1:0] target;
  logic [REG_W-1:0] readMux;
  logic             wrLevel;
  logic             wrDir;

  assign wrLevel = strobe.wrEn && (strobe.sel == SEL_LEVEL);
  assign wrDir   = strobe.wrEn && (strobe.sel == SEL_DIR);
  assign inChg   = gpioIn ^ prevIn;
  assign target  = levelQ & dirQ;
  assign powerQ  = regBank[SEL_POWER];

  // Word bank: status is constant, power has a forcing rule, the rest are plain.
  for (genvar g = 0; g < BANK_N; g++) begin : g_bank
    if (g == int'(SEL_STATUS)) begin : g_status
      assign regBank[g] = STATUS_VAL[REG_W-1:0];
    end else if (g == int'(SEL_POWER)) begin : g_power
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regBank[g] <= '0;
        end else if (strobe.wrEn && strobe.sel == SEL_POWER) begin
          regBank[g] <= wrData[PWR_TRIG] ? (wrData | PWR_FORCE[REG_W-1:0]) : wrData;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regBank[g] <= '0;
        end else if (strobe.wrEn && strobe.sel == regSel_e'(g)) begin
          regBank[g] <= wrData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
    end else if (wrDir) begin
      dirQ <= wrData;
    end
  end

  // The level word: a host write wins over input-line events in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      prevIn <= '0;
    end else begin
      prevIn <= gpioIn;
      if (wrLevel) begin
        levelQ <= wrData & dirQ;
      end else begin
        levelQ <= (levelQ & ~inChg) | (gpioIn & inChg);
      end
    end
  end

  // Each output line is refreshed only where it differs from the masked level.
  for (genvar b = 0; b < REG_W; b++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gpioOut[b] <= 1'b0;
      end else if (strobe.refresh && (gpioOut[b] != target[b])) begin
        gpioOut[b] <= target[b];
      end
    end
  end

  always_comb begin
    readMux = '0;
    case (strobe.sel)
      SEL_DIR:   readMux = dirQ;
      SEL_LEVEL: readMux = levelQ;
      SEL_NONE:  readMux = '0;
      default:   readMux = regBank[strobe.sel[2:0]];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      badAccess <= 1'b0;
    end else begin
      if (strobe.rdEn) begin
        rdData <= readMux;
      end
      badAccess <= strobe.wrEn && (strobe.sel == SEL_NONE);
    end
  end

endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_regblock_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int REG_W  = 16,
  parameter int DEC_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              badAccess,
  input  logic [REG_W-1:0]  gpioIn,
  output logic [REG_W-1:0]  gpioOut
);

  strobe_t          strobe;
  logic [REG_W-1:0] levelQ;
  logic [REG_W-1:0] dirQ;
  logic [REG_W-1:0] powerQ;
  logic             refreshPend;
  logic             unusedHighBits;

  // Upper address and data bits are intentionally discarded.
  assign unusedHighBits = ^{busAddr[ADDR_W-1:DEC_W], busWdata[BUS_W-1:REG_W]};
  assign refreshPend    = strobe.refresh;

  gpio_regblock_ctrl #(.DEC_W(DEC_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .offset (busAddr[DEC_W-1:0]),
    .busWe  (busWe),
    .busRe  (busRe),
    .strobe (strobe)
  );

  gpio_regblock_dp #(.REG_W(REG_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWdata[REG_W-1:0]),
    .gpioIn    (gpioIn),
    .rdData    (busRdata),
    .badAccess (badAccess),
    .gpioOut   (gpioOut),
    .levelQ    (levelQ),
    .dirQ      (dirQ),
    .powerQ    (powerQ)
  );

endmodule

// File: rtl/gpio_regblock_chk.sv
module gpio_regblock_chk #(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [BUS_W-1:0]  busWdata,
  input logic [REG_W-1:0]  busRdata,
  input logic              badAccess,
  input logic [REG_W-1:0]  gpioOut,
  input logic [REG_W-1:0]  levelQ,
  input logic [REG_W-1:0]  dirQ,
  input logic [REG_W-1:0]  powerQ,
  input logic              refreshPend
);

  logic [5:0] off;
  logic       offUndec;
  logic       offLevel;
  logic       offPower;
  logic       offStatus;

  assign off       = busAddr[5:0];
  assign offUndec  = (off[1:0] != 2'b00) || (off[5:2] > 4'd10);
  assign offLevel  = (off == 6'h24) || (off == 6'h28);
  assign offPower  = (off == 6'h0C);
  assign offStatus = (off == 6'h08);

  // R3
  pwr_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWe && offPower && busWdata[7]) |-> ((powerQ & 16'h8040) == 16'h8040));

  // R4
  status_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busRe && offStatus) |-> (busRdata == 16'h0002));

  // R5
  level_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWe && offLevel) |-> (levelQ == $past(busWdata[REG_W-1:0] & dirQ)));

  // R7
  undec_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busRe && offUndec) |-> (busRdata == '0));

  // R7
  bad_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    badAccess |-> $past(busWe && offUndec));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(refreshPend) |-> $stable(gpioOut));

  // R8
  out_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(refreshPend) |-> (gpioOut == $past(levelQ & dirQ)));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busRe) |-> $stable(busRdata));

endmodule

bind gpio_regblock gpio_regblock_chk #(
  .ADDR_W (ADDR_W),
  .BUS_W  (BUS_W),
  .REG_W  (REG_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWe       (busWe),
  .busRe       (busRe),
  .busWdata    (busWdata),
  .busRdata    (busRdata),
  .badAccess   (badAccess),
  .gpioOut     (gpioOut),
  .levelQ      (levelQ),
  .dirQ        (dirQ),
  .powerQ      (powerQ),
  .refreshPend (refreshPend)
);

// File: tb/sim_gpio_regblock.sv
`timescale 1ns/1ps
module sim_gpio_regblock;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        badAccess;
  logic [15:0] gpioIn = '0;
  logic [15:0] gpioOut;

  int checks = 0;
  int errors = 0;

  logic [15:0] mReg [16];
  logic [15:0] mLevel;
  logic [15:0] mOut;
  logic        lastBad;

  always #2.5 clk = ~clk;

  gpio_regblock u0 (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busRe     (busRe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .badAccess (badAccess),
    .gpioIn    (gpioIn),
    .gpioOut   (gpioOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mReg[i] = '0;
    mReg[2] = 16'h0002;
    mLevel = '0;
    mOut = '0;
  endtask

  function automatic logic isBad(input logic [5:0] off);
    return (off[1:0] != 2'b00) || (off[5:2] > 4'd10);
  endfunction

  // Returns 1 when the write schedules an output refresh.
  function automatic logic modelWrite(input logic [5:0] off, input logic [31:0] d);
    logic [15:0] v;
    int idx;
    v = d[15:0];
    idx = int'(off[5:2]);
    if (isBad(off)) return 1'b0;
    if (idx == 2) return 1'b0;
    if (idx == 3) begin
      mReg[3] = v[7] ? (v | 16'h8040) : v;
      return 1'b0;
    end
    if (idx == 9 || idx == 10) begin
      mLevel = v & mReg[8];
      return 1'b1;
    end
    mReg[idx] = v;
    return (idx == 8);
  endfunction

  function automatic logic [15:0] modelRead(input logic [5:0] off);
    int idx;
    idx = int'(off[5:2]);
    if (isBad(off)) return 16'h0000;
    if (idx == 9 || idx == 10) return mLevel;
    return mReg[idx];
  endfunction

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    lastBad = badAccess;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic        refr;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 out", gpioOut, 0);
    check("R11 bad", badAccess, 0);
    check("R11 rdata", busRdata, 0);
    busRead(12'h008, rd); check("R4 status after reset", rd, 16'h0002);
    busRead(12'h020, rd); check("R11 dir", rd, 0);

    // Sweep of all 64 low offsets, twice, with varied upper address bits (R1, R2)
    for (int rnd = 0; rnd < 2; rnd++) begin
      for (int o = 0; o < 64; o++) begin
        logic [5:0]  off;
        logic [11:0] a;
        logic [31:0] d;
        logic [15:0] pat;
        off = o[5:0];
        a = {6'((rnd * 37 + o) % 64), off};
        pat = 16'(o * 16'h1357) ^ (rnd == 0 ? 16'h00FF : 16'h5A5A);
        d = {16'hDEAD ^ 16'(o), pat};
        refr = modelWrite(off, d);
        busWrite(a, d);
        check(isBad(off) ? "R7 bad flag set" : "R7 bad flag clear", lastBad, isBad(off));
        if (refr) mOut = mLevel & mReg[8];
        @(negedge clk);
        check("R8 out after write", gpioOut, mOut);
        check("R7 bad one cycle", badAccess, 0);
        busRead(a, rd);
        check(off == 6'h0C ? "R3 power" : (off == 6'h08 ? "R4 status" :
              (off == 6'h24 || off == 6'h28) ? "R5 level" :
              off == 6'h20 ? "R6 dir" : "R1 R2 readback"), rd, modelRead(off));
      end
      for (int w = 0; w < 16; w++) begin
        logic [11:0] a;
        a = {6'(w * 3), 6'(w * 4)};
        busRead(a, rd);
        check("R6 full readback", rd, modelRead(6'(w * 4)));
      end
    end

    // R3 both branches explicitly
    refr = modelWrite(6'h0C, 32'h0000_0080); busWrite(12'h00C, 32'h0000_0080);
    busRead(12'h00C, rd); check("R3 force", rd, 16'h80C0);
    refr = modelWrite(6'h0C, 32'h0000_0101); busWrite(12'h00C, 32'h0000_0101);
    busRead(12'h00C, rd); check("R3 no force", rd, 16'h0101);

    // R6 alias: write at 0x28 reads at 0x24
    refr = modelWrite(6'h20, 32'h0000_00FF); busWrite(12'h020, 32'h0000_00FF);
    refr = modelWrite(6'h28, 32'h0000_3C5A); busWrite(12'h028, 32'h0000_3C5A);
    mOut = mLevel & mReg[8];
    @(negedge clk);
    busRead(12'h024, rd); check("R6 alias", rd, 16'h005A);
    check("R8 gated out", gpioOut, 16'h005A);

    // R9 input events
    @(negedge clk); gpioIn = 16'hF00F;
    @(negedge clk);
    mLevel = (mLevel & ~16'hF00F) | 16'hF00F;
    busRead(12'h024, rd); check("R9 inputs set", rd, mLevel);
    check("R9 out unchanged", gpioOut, mOut);
    @(negedge clk); gpioIn = 16'h000F;
    @(negedge clk);
    mLevel = mLevel & ~16'hF000;
    busRead(12'h028, rd); check("R9 inputs clear", rd, mLevel);
    check("R9 out unchanged again", gpioOut, mOut);

    // R10 collision: input change and level write together
    @(negedge clk);
    gpioIn = 16'hFFFF; busAddr = 12'h024; busWdata = 32'h0000_1234; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    mLevel = 16'h1234 & mReg[8];
    @(negedge clk);
    busRead(12'h024, rd); check("R10 write wins", rd, mLevel);
    check("R10 out", gpioOut, mLevel & mReg[8]);

    // R11 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R11 out in reset", gpioOut, 0);
    check("R11 rdata in reset", busRdata, 0);
    gpioIn = 16'h0000;
    @(negedge clk); rstN = 1'b1;
    modelReset();
    @(negedge clk);
    busRead(12'h024, rd); check("R11 level cleared", rd, 0);
    busRead(12'h00C, rd); check("R11 power cleared", rd, 0);
    busRead(12'h008, rd); check("R4 status kept", rd, 16'h0002);
    check("R12 rdata holds", busRdata, 16'h0002);
    repeat (2) @(negedge clk);
    check("R12 rdata holds later", busRdata, 16'h0002);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule